// File: doc/BRIEF.md
# Sample Buffer Event Flags

This block sits between the output sample stream of a converter and a short first-in first-out sample store. It tracks whether a conversion is running and keeps a set of sticky raw event flags that the surrounding peripheral can enable, prioritise and route to an interrupt line. The flags report the start of a conversion, its end, samples lost because the store was full, and samples that cross either of two window thresholds. A separate status bit records that a conversion ended before it completed. The data-ready flag is different: it is a level that shows whether the store is empty or not.

The sample input has no back-pressure. A converter cannot be stalled, so `smp_valid` is a strobe and a sample that finds the store full is lost. The read side is a valid/ready stream. `rd_valid` stays high while any sample is stored, `rd_data` shows the oldest sample, and each cycle with `rd_valid && rd_ready` removes exactly one sample. Either a CPU or a transfer engine may drive `rd_ready`. A mode bit selects when the end of an acquisition is flagged: after the store has drained, or at once when the conversion stops. While debug mode is high, start requests are ignored, and a conversion that is running is aborted.

Top module: `smpbuf_flags`

## Requirements
- R1: After reset, `irq_flags`, `istop` and `rd_valid` are all 0.
- R2: A `conv_start` pulse while idle starts a conversion and sets `irq_flags[2]` (start trigger). While `dbg_mode` is high, `conv_start` is ignored and does not set the flag.
- R3: Samples are stored only while a conversion is running, up to 4 of 16 bits each, and read out oldest first. `rd_valid` and `irq_flags[3]` (data ready) are high exactly when the store is not empty. Each cycle with `rd_valid && rd_ready` removes one sample. The clear bit `flag_clr[3]` has no effect.
- R4: A sample that arrives while running, with 4 samples stored and no read in the same cycle, sets `irq_flags[0]` (overflow). That sample is dropped and the stored samples stay unchanged.
- R5: A sample that arrives while running and is greater than `win_hi_th` (unsigned) sets `irq_flags[4]`. This also applies to a sample that is dropped.
- R6: A sample that arrives while running and is less than `win_lo_th` (unsigned) sets `irq_flags[5]`.
- R7: With `xfer_off`=0, the end of a conversion sets `irq_flags[1]` (acquisition done) on the first later clock edge at which the store is empty before that edge.
- R8: With `xfer_off`=1, `irq_flags[1]` is set on the same edge at which the conversion ends, whatever the store holds. The stored samples stay readable.
- R9: `conv_abort`, or `dbg_mode` high while running, ends the conversion and sets `istop`. `istop` is not part of `irq_flags`.
- R10: Each sticky flag (`irq_flags` bits 0, 1, 2, 4, 5 and `istop`, the last one cleared by `flag_clr[6]`) stays set until a `flag_clr` pulse on its bit. If a set event and a clear arrive in the same cycle, the set wins.
- R11: When `conv_stop` and `conv_abort` arrive together, the conversion is treated as interrupted and `istop` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_start | input | 1 | Start request pulse |
| conv_stop | input | 1 | Completed-stop pulse |
| conv_abort | input | 1 | Abort pulse |
| dbg_mode | input | 1 | Debug mode level |
| xfer_off | input | 1 | Acquisition-done rule: 0 waits for drain, 1 flags at once |
| smp_valid | input | 1 | Sample strobe, no back-pressure |
| smp_data | input | 16 | Sample word |
| win_hi_th | input | 16 | Window high threshold |
| win_lo_th | input | 16 | Window low threshold |
| rd_ready | input | 1 | Reader takes the oldest sample |
| rd_valid | output | 1 | Store not empty |
| rd_data | output | 16 | Oldest stored sample |
| flag_clr | input | 7 | Clear pulses, one per flag bit; bit 6 clears istop |
| irq_flags | output | 6 | {win low, win high, data ready, start, acq done, overflow} |
| istop | output | 1 | Incomplete-stop status |

## Verification
On every cycle, the assertions check the bound on the store's level. They also check that an overflow leaves the level unchanged, that a read takes away one sample, that debug mode halts the sequencer and blocks the start flag, that window events raise their flags, that the flags stay set, and that the fast acquisition-done rule holds. Only the bench scenarios can show the order in which samples are read out, the exact cycle in which a drained store releases acquisition-done, and how a stop, an abort and a clear interact within the same cycle. A behavioural model checks these cycle by cycle under directed and random traffic.

// File: rtl/smpbuf_pkg.sv
package smpbuf_pkg;
  localparam int FLG_OVF   = 0;
  localparam int FLG_ACQ   = 1;
  localparam int FLG_STRT  = 2;
  localparam int FLG_RDY   = 3;
  localparam int FLG_WHI   = 4;
  localparam int FLG_WLO   = 5;
  localparam int FLG_ISTOP = 6;
  localparam int N_IRQ     = 6;
  localparam int N_STAT    = 7;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_BUSY = 1'b1
  } run_e;
endpackage

// File: rtl/smpbuf_fifo.sv
module smpbuf_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  logic [DW-1:0]                wdata,
  output logic [DW-1:0]                rdata,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         empty,
  output logic                         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, pop_ok, push_ok;

  assign empty   = (count == '0);
  assign full    = (count == FULLC);
  assign pop_ok  = pop && !empty;
  assign push_ok = push && (!full || pop_ok);
  assign ovf     = push && full && !pop_ok;
  assign rdata   = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop_ok)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULLC);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> $stable(count));
  p_pop_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !empty && !push) |=> (count == $past(count) - 1'b1));
endmodule

// File: rtl/smpbuf_ctrl.sv
module smpbuf_ctrl
  import smpbuf_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic stop,
  input  logic abort,
  input  logic dbg,
  output logic running,
  output logic start_ev,
  output logic end_ev,
  output logic incomplete_ev
);
  run_e st;

  assign running       = (st == RUN_BUSY);
  assign start_ev      = !running && start && !dbg;
  assign incomplete_ev = running && (abort || dbg);
  assign end_ev        = running && (stop || abort || dbg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        st <= RUN_IDLE;
    else if (start_ev) st <= RUN_BUSY;
    else if (end_ev)   st <= RUN_IDLE;
  end

  p_dbg_halts_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg |=> (st == RUN_IDLE));
endmodule

// File: rtl/smpbuf_window.sv
module smpbuf_window #(
  parameter int DW = 16
) (
  input  logic          sample_ev,
  input  logic [DW-1:0] data,
  input  logic [DW-1:0] hi_th,
  input  logic [DW-1:0] lo_th,
  output logic          hi_ev,
  output logic          lo_ev
);
  assign hi_ev = sample_ev && (data > hi_th);
  assign lo_ev = sample_ev && (data < lo_th);
endmodule

// File: rtl/smpbuf_flags.sv
module smpbuf_flags
  import smpbuf_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              conv_start,
  input  logic              conv_stop,
  input  logic              conv_abort,
  input  logic              dbg_mode,
  input  logic              xfer_off,
  input  logic              smp_valid,
  input  logic [DW-1:0]     smp_data,
  input  logic [DW-1:0]     win_hi_th,
  input  logic [DW-1:0]     win_lo_th,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DW-1:0]     rd_data,
  input  logic [N_STAT-1:0] flag_clr,
  output logic [N_IRQ-1:0]  irq_flags,
  output logic              istop
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [N_STAT-1:0] STICKY = ~(N_STAT'(1) << FLG_RDY);

  logic running, start_ev, end_ev, incomplete_ev;
  logic smp_ev, hi_ev, lo_ev, ovf, empty, acq_set, pend_q;
  logic [CW-1:0]     count;
  logic [N_STAT-1:0] set_vec, stat_q;

  smpbuf_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(conv_start), .stop(conv_stop),
    .abort(conv_abort), .dbg(dbg_mode), .running(running),
    .start_ev(start_ev), .end_ev(end_ev), .incomplete_ev(incomplete_ev)
  );

  assign smp_ev = smp_valid && running;

  smpbuf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(smp_ev), .pop(rd_ready),
    .wdata(smp_data), .rdata(rd_data), .count(count),
    .empty(empty), .ovf(ovf)
  );

  smpbuf_window #(.DW(DW)) u_win (
    .sample_ev(smp_ev), .data(smp_data), .hi_th(win_hi_th),
    .lo_th(win_lo_th), .hi_ev(hi_ev), .lo_ev(lo_ev)
  );

  assign acq_set = (end_ev && xfer_off) || (pend_q && empty);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  pend_q <= 1'b0;
    else if (end_ev && !xfer_off) pend_q <= 1'b1;
    else if (pend_q && empty)    pend_q <= 1'b0;
  end

  always_comb begin
    set_vec            = '0;
    set_vec[FLG_OVF]   = ovf;
    set_vec[FLG_ACQ]   = acq_set;
    set_vec[FLG_STRT]  = start_ev;
    set_vec[FLG_WHI]   = hi_ev;
    set_vec[FLG_WLO]   = lo_ev;
    set_vec[FLG_ISTOP] = incomplete_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= ((stat_q & ~flag_clr) | set_vec) & STICKY;
  end

  assign rd_valid = !empty;
  assign istop    = stat_q[FLG_ISTOP];

  generate
    for (genvar g = 0; g < N_IRQ; g++) begin : g_irq
      if (g == FLG_RDY) begin : g_lvl
        assign irq_flags[g] = !empty;
      end else begin : g_stk
        assign irq_flags[g] = stat_q[g];
      end
    end
  endgenerate

  p_winhi_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && running && (smp_data > win_hi_th)) |=> irq_flags[FLG_WHI]);
  p_winlo_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && running && (smp_data < win_lo_th)) |=> irq_flags[FLG_WLO]);
  p_sticky_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flags[FLG_OVF] && !flag_clr[FLG_OVF]) |=> irq_flags[FLG_OVF]);
  p_start_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |=> !$rose(irq_flags[FLG_STRT]));
  p_acq_fast_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (end_ev && xfer_off) |=> irq_flags[FLG_ACQ]);
  p_istop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(istop) |-> !running);
  p_abort_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (running && conv_stop && conv_abort) |=> istop);
endmodule

// File: tb/smpbuf_flags_bench.sv
module smpbuf_flags_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 0, conv_stop = 0, conv_abort = 0, dbg_mode = 0;
  logic        xfer_off = 0, smp_valid = 0, rd_ready = 0;
  logic [15:0] smp_data = '0, win_hi_th = 16'd100, win_lo_th = 16'd5;
  logic [6:0]  flag_clr = '0;
  logic        rd_valid, istop;
  logic [15:0] rd_data;
  logic [5:0]  irq_flags;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_on = 0;

  always #2 clk = ~clk;

  smpbuf_flags u_smpbuf_flags (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .conv_stop(conv_stop),
    .conv_abort(conv_abort), .dbg_mode(dbg_mode), .xfer_off(xfer_off),
    .smp_valid(smp_valid), .smp_data(smp_data), .win_hi_th(win_hi_th),
    .win_lo_th(win_lo_th), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .flag_clr(flag_clr), .irq_flags(irq_flags), .istop(istop)
  );

  // behavioural reference model
  int        q[$];
  bit        m_run, m_pend;
  bit [6:0]  m_flags, m_set;
  int        m_pre;
  bit        m_pop, m_end, m_smp;

  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); m_run = 0; m_pend = 0; m_flags = '0;
    end else begin
      m_pre = q.size();
      m_pop = rd_ready && (m_pre > 0);
      m_end = m_run && (conv_stop || conv_abort || dbg_mode);
      m_smp = smp_valid && m_run;
      m_set = '0;
      m_set[2] = !m_run && conv_start && !dbg_mode;
      m_set[6] = m_run && (conv_abort || dbg_mode);
      m_set[4] = m_smp && (smp_data > win_hi_th);
      m_set[5] = m_smp && (smp_data < win_lo_th);
      m_set[1] = (m_end && xfer_off) || (m_pend && m_pre == 0);
      if (m_pop) void'(q.pop_front());
      if (m_smp) begin
        if (q.size() < 4) q.push_back(int'(smp_data));
        else m_set[0] = 1'b1;
      end
      if (m_end && !xfer_off) m_pend = 1;
      else if (m_pend && m_pre == 0) m_pend = 0;
      if (m_set[2]) m_run = 1;
      else if (m_end) m_run = 0;
      m_flags = (m_flags & ~flag_clr) | m_set;
      m_flags[3] = 1'b0;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && rst_n) begin
      chk("R4 overflow", irq_flags[0], m_flags[0]);
      chk("R7/R8 acq done", irq_flags[1], m_flags[1]);
      chk("R2 start", irq_flags[2], m_flags[2]);
      chk("R3 data ready", irq_flags[3], q.size() != 0);
      chk("R3 rd_valid", rd_valid, q.size() != 0);
      if (q.size() != 0) chk("R3 rd_data", rd_data, q[0]);
      chk("R5 win high", irq_flags[4], m_flags[4]);
      chk("R6 win low", irq_flags[5], m_flags[5]);
      chk("R9 istop", istop, m_flags[6]);
    end
  end

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse_start();
    conv_start = 1; cyc(1); conv_start = 0;
  endtask

  task automatic push(input logic [15:0] d);
    smp_valid = 1; smp_data = d; cyc(1); smp_valid = 0;
  endtask

  task automatic read_one(input logic [15:0] exp);
    chk("R3 order", rd_data, exp);
    rd_ready = 1; cyc(1); rd_ready = 0;
  endtask

  task automatic clear_all();
    flag_clr = 7'h7f; cyc(1); flag_clr = '0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(1);
    chk("R1 flags", irq_flags, 0);
    chk("R1 istop", istop, 0);
    chk("R1 rd_valid", rd_valid, 0);
    cmp_on = 1;

    push(16'd7); cyc(1);
    chk("R3 idle sample ignored", rd_valid, 0);

    dbg_mode = 1; pulse_start(); dbg_mode = 0; cyc(1);
    chk("R2 start in debug", irq_flags[2], 0);

    pulse_start();
    chk("R2 start flag", irq_flags[2], 1);
    push(16'd10); push(16'd20); push(16'd30); push(16'd40);
    chk("R4 no overflow at four", irq_flags[0], 0);
    push(16'd200);
    chk("R4 overflow", irq_flags[0], 1);
    chk("R5 dropped sample high", irq_flags[4], 1);
    chk("R6 no low yet", irq_flags[5], 0);

    flag_clr = 7'b0001001; cyc(1); flag_clr = '0;
    chk("R10 clear ovf", irq_flags[0], 0);
    chk("R3 clear ready no effect", rd_valid, 1);
    flag_clr = 7'b0000001; smp_valid = 1; smp_data = 16'd50; cyc(1);
    smp_valid = 0; flag_clr = '0;
    chk("R10 set beats clear", irq_flags[0], 1);

    xfer_off = 0; conv_stop = 1; cyc(1); conv_stop = 0;
    cyc(2);
    chk("R7 waits for drain", irq_flags[1], 0);
    read_one(16'd10); read_one(16'd20); read_one(16'd30); read_one(16'd40);
    chk("R7 not same edge", irq_flags[1], 0);
    cyc(1);
    chk("R7 after drain", irq_flags[1], 1);
    clear_all();

    pulse_start();
    push(16'd3); push(16'd60);
    chk("R6 low flag", irq_flags[5], 1);
    xfer_off = 1; conv_stop = 1; cyc(1); conv_stop = 0;
    chk("R8 immediate acq", irq_flags[1], 1);
    chk("R8 data still held", rd_valid, 1);
    read_one(16'd3); read_one(16'd60);
    chk("R8 drained", rd_valid, 0);
    clear_all();

    pulse_start();
    conv_stop = 1; conv_abort = 1; cyc(1); conv_stop = 0; conv_abort = 0;
    chk("R11 abort wins", istop, 1);
    chk("R9 istop not irq", irq_flags[5:4], 0);
    flag_clr = 7'b1000000; cyc(1); flag_clr = '0;
    chk("R10 clear istop", istop, 0);
    clear_all();

    pulse_start();
    cyc(2);
    dbg_mode = 1; conv_start = 1; cyc(1); conv_start = 0;
    chk("R9 debug abort", istop, 1);
    flag_clr = 7'b0000100; cyc(1); flag_clr = '0;
    conv_start = 1; cyc(1); conv_start = 0;
    chk("R2 start blocked in debug", irq_flags[2], 0);
    dbg_mode = 0;
    clear_all();

    for (int i = 0; i < 4000; i++) begin
      conv_start = ($urandom_range(0, 15) == 0);
      conv_stop  = ($urandom_range(0, 31) == 0);
      conv_abort = ($urandom_range(0, 63) == 0);
      dbg_mode   = ($urandom_range(0, 127) == 0);
      xfer_off   = ($urandom_range(0, 1) == 1);
      smp_valid  = ($urandom_range(0, 1) == 1);
      smp_data   = 16'($urandom_range(0, 160));
      rd_ready   = ($urandom_range(0, 2) == 0);
      flag_clr   = ($urandom_range(0, 7) == 0) ? 7'($urandom) : 7'd0;
      cyc(1);
    end
    conv_start = 0; conv_stop = 0; conv_abort = 0; dbg_mode = 0;
    smp_valid = 0; rd_ready = 0; flag_clr = '0;
    cyc(2);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule